// File: doc/BRIEF.md
# Latched Status Register Bank

The block holds three 8-bit registers of latched hardware conditions: two status registers that can raise interrupts and one information register that cannot. Each event input bit sets its own latched bit, which stays at 1 after the condition goes away. A host reaches the bank through a small synchronous register port with a write strobe, a read strobe, a 3-bit address and 8-bit data.

Polling takes two steps. The host first writes a selection mask to a register. Each selected bit copies its latched value into a read-back register and clears the latched bit. The following read returns the read-back register. Bits the mask leaves out keep both their read-back value and their latched value. Events arrive independently of the host. A second write of (read value AND mask) therefore clears again any selected bit that an event set between the two accesses.

Every bit is either edge-type or level-type, fixed by a parameter. An edge-type bit sets only on a new rising transition of its input. A level-type bit, such as a loss-of-synchronization flag, sets again on every cycle that its input stays high. Each status register has its own 8-bit interrupt mask register and its own active-low interrupt output.

Top module: `stat_bank_top`

## Requirements
- R1: A high level on a bit of `evt_s1`, `evt_s2` or `evt_inf` sets the same bit of status register 1 (address 0), status register 2 (address 1) or the information register (address 2). The bit is set within three clock cycles.
- R2: A latched bit stays 1 until the host clears it with a mask write, even after its input has returned to 0.
- R3: For each bit written as 1 in a mask write to address 0, 1 or 2, the read-back bit takes the latched value from before the write and the latched bit is cleared. A read strobe puts the selected value on `host_rdata` one cycle later, where it holds until the next read.
- R4: For each bit written as 0 in such a mask write, the read-back bit keeps its previous value and the latched bit is left unchanged.
- R5: An edge-type bit that has been cleared sets again only after its input goes low and then high again. Holding the input high does not set it again.
- R6: A level-type bit sets again on every cycle that its input stays high. By default the level-type bits are status register 1 bit 0 and information register bits 0 and 1. All other bits are edge-type.
- R7: If an event sets a bit in the same cycle as a mask write clears it, the bit ends up set. The read-back bit takes the value from before that cycle, and a second mask write returns the event.
- R8: `irq1_n` is low exactly while (status register 1 AND interrupt mask 1) is nonzero. `irq2_n` follows the same rule for status register 2 and interrupt mask 2. The information register affects neither output.
- R9: Interrupt mask 1 (address 3) and interrupt mask 2 (address 4) are written with a plain write and read back through the same port.
- R10: Reset clears all latched bits, read-back values, interrupt masks and `host_rdata`. Both interrupt outputs are high after reset.
- R11: A write to address 5, 6 or 7 changes no register, and a read of any of these addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data: selection mask or interrupt mask |
| host_rdata | output | 8 | Registered read data |
| evt_s1 | input | 8 | Event inputs of status register 1, asynchronous |
| evt_s2 | input | 8 | Event inputs of status register 2, asynchronous |
| evt_inf | input | 8 | Event inputs of the information register, asynchronous |
| irq1_n | output | 1 | Active-low interrupt from status register 1 |
| irq2_n | output | 1 | Active-low interrupt from status register 2 |

## Verification
The assertions assume that the host raises each strobe for a single cycle, never raises both strobes in the same cycle, and holds reset low for at least two clock edges. Under those conditions the read-back register, the latch and the interrupt outputs have defined past values. The bench drives every strobe and event from the falling clock edge in one-cycle tasks. It holds events for at least two cycles before it reads, except in the one scenario that times an event pulse to meet a mask write in the same clock edge.

// File: rtl/stat_bank_pkg.sv
// Package: shared constants and the register address map of the status bank.
// Assumes a 3-bit host address; addresses 5..7 are unused.
package stat_bank_pkg;
    localparam int NREG = 3;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        A_STAT1  = 3'd0,
        A_STAT2  = 3'd1,
        A_INFO   = 3'd2,
        A_IMASK1 = 3'd3,
        A_IMASK2 = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/evt_sync.sv
// Module: two-flop synchronizer for a vector of independent event inputs.
// Assumes each bit is a slow level or a pulse of at least one clock period;
// no coherence across bits is implied.
module evt_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two register stages bring the inputs into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/stat_reg.sv
// Module: one latched status register with a masked snapshot-and-clear.
// A mask write copies the selected latched bits into the read-back register
// and clears them; a new event in the same cycle wins over the clear.
// LEVEL picks which bits re-set while their input is high (others are edge).
// Assumes evt is already synchronous to clk.
module stat_reg #(
    parameter int           W     = 8,
    parameter logic [W-1:0] LEVEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_sel,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] lat,
    output logic [W-1:0] rb
);
    logic [W-1:0] evt_prev;
    logic [W-1:0] set_v;
    logic [W-1:0] clr;

    // Level bits set while high, edge bits set only on a rising transition.
    always_comb begin
        set_v = (evt & LEVEL) | (evt & ~evt_prev & ~LEVEL);
        clr   = wr_sel ? wmask : '0;
    end

    // Delay stage used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= '0;
        else        evt_prev <= evt;
    end

    // Latch update: selected bits clear, new events set, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) lat <= '0;
        else        lat <= (lat & ~clr) | set_v;
    end

    // Read-back update: selected bits load the latched value, others hold.
    always_ff @(posedge clk) begin
        if (!rst_n) rb <= '0;
        else        rb <= (rb & ~clr) | (lat & clr);
    end

    // R2
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(lat & ~clr) |=> ((lat & $past(lat & ~clr)) == $past(lat & ~clr)));

    // R3
    lat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr & ~set_v & lat) |=> ((lat & $past(clr & ~set_v)) == '0));

    // R3
    rb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |clr |=> ((rb & $past(clr)) == ($past(lat) & $past(clr))));

    // R4
    rb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rb ^ $past(rb)) & ~$past(clr)) == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |set_v |=> ((lat & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/stat_bank_top.sv
// Module: bank of two interrupting status registers and one information
// register behind a synchronous host register port, with two interrupt masks.
// Assumes one-cycle strobes, never both strobes in one cycle, and
// asynchronous event inputs.
module stat_bank_top
    import stat_bank_pkg::*;
#(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] LVL_S1  = 8'h01,
    parameter logic [DW-1:0] LVL_S2  = 8'h00,
    parameter logic [DW-1:0] LVL_INF = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] evt_s1,
    input  logic [DW-1:0] evt_s2,
    input  logic [DW-1:0] evt_inf,
    output logic          irq1_n,
    output logic          irq2_n
);
    logic [NREG-1:0][DW-1:0] evt_raw;
    logic [NREG-1:0][DW-1:0] evt_sy;
    logic [NREG-1:0][DW-1:0] lat_all;
    logic [NREG-1:0][DW-1:0] rb_all;
    logic [NREG-1:0][DW-1:0] imask_all;
    logic [NREG-1:0]         wr_stat;
    logic [NREG-1:0]         irq_vec;
    logic [DW-1:0]           imask1_q;
    logic [DW-1:0]           imask2_q;
    logic [DW-1:0]           rd_mux;
    logic                    info_irq_unused;

    // Gather the event vectors and the masks in register order.
    always_comb begin
        evt_raw[0]   = evt_s1;
        evt_raw[1]   = evt_s2;
        evt_raw[2]   = evt_inf;
        imask_all[0] = imask1_q;
        imask_all[1] = imask2_q;
        imask_all[2] = '0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            localparam logic [DW-1:0] LV =
                (gi == 0) ? LVL_S1 : ((gi == 1) ? LVL_S2 : LVL_INF);

            assign wr_stat[gi] = host_wr && (host_addr == AW'(gi));

            evt_sync #(.W(DW)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (evt_raw[gi]),
                .q_sync  (evt_sy[gi])
            );

            stat_reg #(.W(DW), .LEVEL(LV)) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt_sy[gi]),
                .wr_sel (wr_stat[gi]),
                .wmask  (host_wdata),
                .lat    (lat_all[gi]),
                .rb     (rb_all[gi])
            );

            assign irq_vec[gi] = |(lat_all[gi] & imask_all[gi]);
        end
    endgenerate

    assign irq1_n          = ~irq_vec[0];
    assign irq2_n          = ~irq_vec[1];
    assign info_irq_unused = irq_vec[2];

    // Interrupt mask registers, plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask1_q <= '0;
            imask2_q <= '0;
        end else if (host_wr) begin
            if (host_addr == A_IMASK1) imask1_q <= host_wdata;
            if (host_addr == A_IMASK2) imask2_q <= host_wdata;
        end
    end

    // Read-data select by address; unused addresses give zero.
    always_comb begin
        case (host_addr)
            A_STAT1:  rd_mux = rb_all[0];
            A_STAT2:  rd_mux = rb_all[1];
            A_INFO:   rd_mux = rb_all[2];
            A_IMASK1: rd_mux = imask1_q;
            A_IMASK2: rd_mux = imask2_q;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read port, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // R8
    irq1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_IMASK1 && host_wdata == '0) |=> irq1_n);

    // R8
    irq2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_IMASK2 && host_wdata == '0) |=> irq2_n);

    // R11
    unused_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr > 3'd4) |=> (host_rdata == '0));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/stat_bank_top_tb_top.sv
module stat_bank_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] evt_s1 = '0;
    logic [7:0] evt_s2 = '0;
    logic [7:0] evt_inf = '0;
    logic       irq1_n;
    logic       irq2_n;

    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    stat_bank_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_s1(evt_s1), .evt_s2(evt_s2), .evt_inf(evt_inf),
        .irq1_n(irq1_n), .irq2_n(irq2_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), rv);
            check("R10 reset read", rv, 8'h00);
        end
        check("R10 irq1_n after reset", {7'd0, irq1_n}, 8'h01);
        check("R10 irq2_n after reset", {7'd0, irq2_n}, 8'h01);
    endtask

    task automatic t_unused;
        wr(3'd5, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd5, rv); check("R11 unused read", rv, 8'h00);
        rd(3'd3, rv); check("R11 imask1 untouched", rv, 8'h00);
        rd(3'd4, rv); check("R11 imask2 untouched", rv, 8'h00);
        check("R11 irq1_n high", {7'd0, irq1_n}, 8'h01);
    endtask

    task automatic t_edge_latch;
        @(negedge clk) evt_s2[3] = 1'b1;
        @(negedge clk) evt_s2[3] = 1'b0;
        idle(5);
        wr(3'd1, 8'hFF); rd(3'd1, rv); check("R1 R2 latched pulse", rv, 8'h08);
        wr(3'd1, 8'hFF); rd(3'd1, rv); check("R5 edge bit stays clear", rv, 8'h00);
    endtask

    task automatic t_partial;
        @(negedge clk) evt_s1 = 8'h06;
        @(negedge clk) evt_s1 = 8'h00;
        idle(5);
        wr(3'd0, 8'h02); rd(3'd0, rv); check("R3 selected bit", rv, 8'h02);
        wr(3'd0, 8'h04); rd(3'd0, rv); check("R4 unselected kept", rv, 8'h06);
        wr(3'd0, 8'h06); rd(3'd0, rv); check("R3 both cleared", rv, 8'h00);
    endtask

    task automatic t_level;
        @(negedge clk) evt_s1[0] = 1'b1;
        idle(5);
        wr(3'd0, 8'h01); rd(3'd0, rv); check("R6 level first", rv, 8'h01);
        wr(3'd0, 8'h01); rd(3'd0, rv); check("R6 level re-set", rv, 8'h01);
        @(negedge clk) evt_s1[0] = 1'b0;
        idle(5);
        wr(3'd0, 8'h01); rd(3'd0, rv); check("R2 level held after release", rv, 8'h01);
        wr(3'd0, 8'h01); rd(3'd0, rv); check("R6 level clear after release", rv, 8'h00);
        @(negedge clk) evt_inf[5] = 1'b1;
        idle(5);
        wr(3'd2, 8'h20); rd(3'd2, rv); check("R1 info edge bit", rv, 8'h20);
        wr(3'd2, 8'h20); rd(3'd2, rv); check("R5 held edge not re-set", rv, 8'h00);
        @(negedge clk) evt_inf[5] = 1'b0;
        @(negedge clk) evt_inf[1] = 1'b1;
        idle(5);
        wr(3'd2, 8'h02); wr(3'd2, 8'h02); rd(3'd2, rv);
        check("R6 info level re-set", rv, 8'h02);
        @(negedge clk) evt_inf[1] = 1'b0;
        idle(5);
        wr(3'd2, 8'h02); wr(3'd2, 8'h02); rd(3'd2, rv);
        check("R6 info level cleared", rv, 8'h00);
    endtask

    task automatic t_set_wins;
        // Pulse timed so the latch sets at the same edge as the mask write.
        @(negedge clk) evt_s2[0] = 1'b1;
        @(negedge clk) evt_s2[0] = 1'b0;
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd1; host_wdata = 8'h01;
        @(negedge clk) host_wr = 1'b0;
        rd(3'd1, rv); check("R7 snapshot before set", rv, 8'h00);
        wr(3'd1, 8'h01); rd(3'd1, rv); check("R7 set survived clear", rv, 8'h01);
        wr(3'd1, 8'h01); rd(3'd1, rv); check("R7 second clear", rv, 8'h00);
    endtask

    task automatic t_irq;
        wr(3'd3, 8'h04); rd(3'd3, rv); check("R9 imask1 readback", rv, 8'h04);
        wr(3'd4, 8'h80); rd(3'd4, rv); check("R9 imask2 readback", rv, 8'h80);
        @(negedge clk) evt_s1[3] = 1'b1;
        @(negedge clk) evt_s1[3] = 1'b0;
        idle(5);
        check("R8 masked bit no irq1", {7'd0, irq1_n}, 8'h01);
        @(negedge clk) evt_s1[2] = 1'b1;
        @(negedge clk) evt_s1[2] = 1'b0;
        idle(5);
        check("R8 irq1 asserted", {7'd0, irq1_n}, 8'h00);
        check("R8 irq2 idle", {7'd0, irq2_n}, 8'h01);
        wr(3'd0, 8'h04);
        check("R8 irq1 released on clear", {7'd0, irq1_n}, 8'h01);
        wr(3'd0, 8'h08);
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        @(negedge clk) evt_inf[6] = 1'b1;
        @(negedge clk) evt_inf[6] = 1'b0;
        idle(5);
        check("R8 info no irq1", {7'd0, irq1_n}, 8'h01);
        check("R8 info no irq2", {7'd0, irq2_n}, 8'h01);
        wr(3'd2, 8'h40); rd(3'd2, rv); check("R1 info bit6 latched", rv, 8'h40);
        @(negedge clk) evt_s2[7] = 1'b1;
        @(negedge clk) evt_s2[7] = 1'b0;
        idle(5);
        check("R8 irq2 asserted", {7'd0, irq2_n}, 8'h00);
        check("R8 irq1 stays idle", {7'd0, irq1_n}, 8'h01);
        wr(3'd4, 8'h00);
        check("R8 irq2 off by mask", {7'd0, irq2_n}, 8'h01);
        wr(3'd1, 8'h80); rd(3'd1, rv); check("R2 s2 bit7 held", rv, 8'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_unused();
        t_edge_latch();
        t_partial();
        t_level();
        t_set_wins();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule